// File: doc/BRIEF.md
# Chained-Descriptor Source Fetcher

This block is a read-only DMA engine that feeds the input bytes of a message to a hashing core. Software programs a few configuration registers and then writes a mode word with its enable bit set. The block reads the message from memory through a single-outstanding read port. It hands the bytes on as 32-bit little-endian beats over a valid/ready stream.

There are two ways to describe the source. In direct mode, one start address and one byte count name the source. In chained mode, the engine walks a list of descriptors held in memory. Each descriptor is four consecutive 32-bit words, in this order: data address, byte length, address of the next descriptor, and a flag word. A set bit 31 in the flag word makes that descriptor the last one in the list.

When every byte has been accepted by the consumer, the engine raises a source-done cause. This happens even though the hashing core may still be working on the data. A read error from memory raises an error cause and stops the engine. Each cause can be routed to an interrupt line through an enable register and a global unmask bit.

Top module: `ll_src_fetch`

## Requirements
- R1: In direct mode (mode word bit 31 set, bit 25 clear), the engine reads words starting at the address in register 0x400. It emits `src_size` bytes, where `src_size` is the value of register 0x408. Each beat carries the memory word unchanged in `out_data_o` (byte 0 in bits 7:0). `out_bytes_o` is 4 on every beat except the last one of a chunk, where it is 1 to 4.
- R2: In chained mode (bits 31 and 25 set), the engine reads the descriptor at the address in register 0x418. It then follows each descriptor's next pointer (word 2) and emits each descriptor's data from its address (word 0) and length (word 1).
- R3: After a descriptor whose flag word (word 3) has bit 31 set, the engine stops once that descriptor's data is sent. It never reads the next-pointer address of that descriptor.
- R4: A descriptor with length 0 produces no beat, and the walk continues with its successor.
- R5: `out_last_o` is high on the final beat of the whole transfer and on no other beat. While `out_valid_o` is high and `out_ready_i` is low, the data, byte count and last flag hold steady.
- R6: Status bit 0 (source done) in register 0x480 is set after the final beat is accepted. `irq_o` is high when a status bit is set, its enable bit in 0x484 is set, and bit 0 of 0x488 is 1.
- R7: Writing to register 0x480 clears the status bits written as 1 and leaves the bits written as 0 unchanged.
- R8: A memory read error during a descriptor or data fetch sets status bit 4, does not set bit 0, and halts the engine. After the error there are no further beats and no further read requests.
- R9: While bit 0 of register 0x488 is 0, `irq_o` stays low even with a status bit pending and enabled.
- R10: The mode register at 0x410 reads back all its written bits, including the 3-bit field at bits 30:28, which has no effect. A mode write while the engine is busy does not start a new transfer.
- R11: After reset, the status reads 0, and `irq_o`, `out_valid_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | CFG_AW | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` (combinational) |
| mem_req_o | output | 1 | Read request, held until `mem_rvalid_i` |
| mem_addr_o | output | AW | Read byte address (word aligned) |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Read response carries an error |
| out_valid_o | output | 1 | Stream beat valid |
| out_ready_i | input | 1 | Consumer accepts the beat |
| out_data_o | output | 32 | Beat data, little-endian byte order |
| out_bytes_o | output | 3 | Count of valid low bytes in the beat (1 to 4) |
| out_last_o | output | 1 | Final beat of the transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on two properties of the memory port:
- It returns exactly one response per request.
- It returns that response only while the request is still held.

The bench's memory model answers one cycle after it sees a request and suppresses a second response in the cycle after it has answered. All data and descriptor addresses are word aligned, which the engine requires. The consumer's ready is toggled in a fixed irregular pattern, so that backpressure hits both middle beats and final beats. Mode writes that start a transfer are issued only while the engine is idle, except for the one deliberate write while busy.

// File: rtl/ll_fetch_pkg.sv
package ll_fetch_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned STAT_W  = 9;

  localparam logic [11:0] OFS_SRC_ADDR  = 12'h400;
  localparam logic [11:0] OFS_SRC_SIZE  = 12'h408;
  localparam logic [11:0] OFS_DST_SIZE  = 12'h40C;
  localparam logic [11:0] OFS_MODE      = 12'h410;
  localparam logic [11:0] OFS_FIRST_DSC = 12'h418;
  localparam logic [11:0] OFS_STATUS    = 12'h480;
  localparam logic [11:0] OFS_IRQ_EN    = 12'h484;
  localparam logic [11:0] OFS_IRQ_MASK  = 12'h488;

  localparam int unsigned MODE_RUN_BIT   = 31;
  localparam int unsigned MODE_CHAIN_BIT = 25;
  localparam int unsigned DSC_TERM_BIT   = 31;
  localparam int unsigned ST_DONE_BIT    = 0;
  localparam int unsigned ST_RDERR_BIT   = 4;

  typedef enum logic [2:0] {
    FS_IDLE, FS_DESC, FS_CHK, FS_DATA, FS_OUT, FS_DONE, FS_ERR
  } fetch_state_e;
endpackage

// File: rtl/ll_fetch_regs.sv
module ll_fetch_regs
  import ll_fetch_pkg::*;
#(
  parameter int unsigned CFG_AW = 12,
  parameter int unsigned AW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic              start_o,
  output logic              chain_o,
  output logic [AW-1:0]     src_addr_o,
  output logic [WORD_W-1:0] src_size_o,
  output logic [AW-1:0]     first_dsc_o,
  output logic              irq_o
);
  localparam int unsigned OFS_W = (CFG_AW < 12) ? CFG_AW : 12;

  logic [WORD_W-1:0] mode_q, src_size_q;
  logic [AW-1:0]     src_addr_q, first_dsc_q;
  logic [STAT_W-1:0] status_q, irq_en_q;
  logic              unmask_q;
  logic [11:0]       ofs;

  always_comb begin
    ofs = '0;
    ofs[OFS_W-1:0] = cfg_addr_i[OFS_W-1:0];
  end

  function automatic logic hit(input logic [11:0] a, input logic [11:0] o);
    return a == o;
  endfunction

  assign start_o = cfg_we_i && hit(ofs, OFS_MODE) && cfg_wdata_i[MODE_RUN_BIT] && !busy_i;
  assign chain_o = cfg_wdata_i[MODE_CHAIN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      src_size_q  <= '0;
      src_addr_q  <= '0;
      first_dsc_q <= '0;
      status_q    <= '0;
      irq_en_q    <= '0;
      unmask_q    <= 1'b0;
    end else begin
      logic [STAT_W-1:0] st_nxt;
      st_nxt = status_q;
      if (cfg_we_i) begin
        if (hit(ofs, OFS_MODE))      mode_q      <= cfg_wdata_i;
        if (hit(ofs, OFS_SRC_ADDR))  src_addr_q  <= cfg_wdata_i[AW-1:0];
        if (hit(ofs, OFS_SRC_SIZE))  src_size_q  <= cfg_wdata_i;
        if (hit(ofs, OFS_FIRST_DSC)) first_dsc_q <= cfg_wdata_i[AW-1:0];
        if (hit(ofs, OFS_IRQ_EN))    irq_en_q    <= cfg_wdata_i[STAT_W-1:0];
        if (hit(ofs, OFS_IRQ_MASK))  unmask_q    <= cfg_wdata_i[0];
        if (hit(ofs, OFS_STATUS))    st_nxt      = st_nxt & ~cfg_wdata_i[STAT_W-1:0];
      end
      // new events win over a same-cycle clear
      if (done_i) st_nxt[ST_DONE_BIT]  = 1'b1;
      if (err_i)  st_nxt[ST_RDERR_BIT] = 1'b1;
      status_q <= st_nxt;
    end
  end

  assign src_addr_o  = src_addr_q;
  assign src_size_o  = src_size_q;
  assign first_dsc_o = first_dsc_q;
  assign irq_o       = unmask_q && |(status_q & irq_en_q);

  always_comb begin
    cfg_rdata_o = '0;
    unique case (ofs)
      OFS_MODE:      cfg_rdata_o = mode_q;
      OFS_SRC_ADDR:  cfg_rdata_o[AW-1:0] = src_addr_q;
      OFS_SRC_SIZE:  cfg_rdata_o = src_size_q;
      OFS_FIRST_DSC: cfg_rdata_o[AW-1:0] = first_dsc_q;
      OFS_STATUS:    cfg_rdata_o[STAT_W-1:0] = status_q;
      OFS_IRQ_EN:    cfg_rdata_o[STAT_W-1:0] = irq_en_q;
      OFS_IRQ_MASK:  cfg_rdata_o[0] = unmask_q;
      default:       cfg_rdata_o = '0;
    endcase
  end

  // R6: a done event is visible in status on the next cycle
  p_done_sets_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_q[ST_DONE_BIT]);
  // R7: clearing bit 0 with no new done leaves it clear
  p_w1c_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && hit(ofs, OFS_STATUS) && cfg_wdata_i[ST_DONE_BIT] && !done_i)
      |=> !status_q[ST_DONE_BIT]);
  // R8: a read error is recorded
  p_err_sets_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> status_q[ST_RDERR_BIT]);
endmodule

// File: rtl/ll_fetch_engine.sv
module ll_fetch_engine
  import ll_fetch_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [WORD_W-1:0] src_size_i,
  input  logic [AW-1:0]     first_dsc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic [2:0]        out_bytes_o,
  output logic              out_last_o
);
  localparam int unsigned BPW = WORD_W / 8;

  fetch_state_e      state_q;
  logic [AW-1:0]     dsc_q, dat_q, nxt_q;
  logic [WORD_W-1:0] remain_q;
  logic [1:0]        widx_q;
  logic              term_q;

  assign busy_o     = state_q != FS_IDLE;
  assign done_o     = state_q == FS_DONE;
  assign err_o      = state_q == FS_ERR;
  assign mem_req_o  = (state_q == FS_DESC) || (state_q == FS_DATA);
  assign mem_addr_o = (state_q == FS_DESC) ? dsc_q + AW'({widx_q, 2'b00}) : dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FS_IDLE;
      dsc_q       <= '0;
      dat_q       <= '0;
      nxt_q       <= '0;
      remain_q    <= '0;
      widx_q      <= '0;
      term_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_bytes_o <= '0;
      out_last_o  <= 1'b0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          if (chain_i) begin
            dsc_q   <= first_dsc_i;
            widx_q  <= '0;
            state_q <= FS_DESC;
          end else begin
            dat_q    <= src_addr_i;
            remain_q <= src_size_i;
            term_q   <= 1'b1;
            state_q  <= FS_CHK;
          end
        end
        FS_DESC: if (mem_rvalid_i) begin
          if (mem_err_i) state_q <= FS_ERR;
          else begin
            unique case (widx_q)
              2'd0: dat_q    <= mem_rdata_i[AW-1:0];
              2'd1: remain_q <= mem_rdata_i;
              2'd2: nxt_q    <= mem_rdata_i[AW-1:0];
              default: begin
                term_q  <= mem_rdata_i[DSC_TERM_BIT];
                state_q <= FS_CHK;
              end
            endcase
            widx_q <= widx_q + 2'd1;
          end
        end
        FS_CHK: begin
          if (remain_q == '0) begin
            if (term_q) state_q <= FS_DONE;
            else begin
              dsc_q   <= nxt_q;
              widx_q  <= '0;
              state_q <= FS_DESC;
            end
          end else state_q <= FS_DATA;
        end
        FS_DATA: if (mem_rvalid_i) begin
          if (mem_err_i) state_q <= FS_ERR;
          else begin
            out_data_o  <= mem_rdata_i;
            out_bytes_o <= (remain_q > BPW) ? 3'(BPW) : remain_q[2:0];
            out_last_o  <= term_q && (remain_q <= BPW);
            out_valid_o <= 1'b1;
            state_q     <= FS_OUT;
          end
        end
        FS_OUT: if (out_ready_i) begin
          out_valid_o <= 1'b0;
          dat_q       <= dat_q + AW'(BPW);
          remain_q    <= remain_q - WORD_W'(out_bytes_o);
          state_q     <= FS_CHK;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // R5: a stalled beat holds its payload
  p_hold_under_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_bytes_o) && $stable(out_last_o)));
  // R1: beat byte count is between 1 and 4
  p_bytes_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_bytes_o != 3'd0 && out_bytes_o <= 3'(BPW)));
  // R8: after an error nothing more is requested or sent
  p_halt_on_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!out_valid_o && !mem_req_o));
  // R5: only a final beat can announce the end of the transfer
  p_last_then_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> ##1 done_o);
  p_req_not_with_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !mem_req_o);
endmodule

// File: rtl/ll_src_fetch.sv
module ll_src_fetch
  import ll_fetch_pkg::*;
#(
  parameter int unsigned CFG_AW = 12,
  parameter int unsigned AW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_data_o,
  output logic [2:0]        out_bytes_o,
  output logic              out_last_o,
  output logic              irq_o
);
  logic              start, chain, busy, done, err;
  logic [AW-1:0]     src_addr, first_dsc;
  logic [WORD_W-1:0] src_size;

  ll_fetch_regs #(.CFG_AW(CFG_AW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .busy_i(busy), .done_i(done), .err_i(err),
    .start_o(start), .chain_o(chain), .src_addr_o(src_addr),
    .src_size_o(src_size), .first_dsc_o(first_dsc), .irq_o
  );

  ll_fetch_engine #(.AW(AW)) u_engine (
    .clk_i, .rst_ni,
    .start_i(start), .chain_i(chain), .src_addr_i(src_addr),
    .src_size_i(src_size), .first_dsc_i(first_dsc),
    .busy_o(busy), .done_o(done), .err_o(err),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i, .mem_err_i,
    .out_valid_o, .out_ready_i, .out_data_o, .out_bytes_o, .out_last_o
  );

  // R10: a start is only taken while idle
  p_no_restart_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !start);
endmodule

// File: tb/tb_ll_src_fetch.sv
module tb_ll_src_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        out_valid, out_ready = 1'b0, out_last, irq;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;

  always #4 clk = ~clk;

  ll_src_fetch dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_bytes_o(out_bytes), .out_last_o(out_last), .irq_o(irq)
  );

  logic [31:0] mem [256];
  logic [31:0] poison_addr = 32'hFFFF_FFFF;
  logic        poison_hit = 1'b0;

  // memory model: answers one cycle after a request, error in 0x3C4..0x3CF
  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[9:2]];
    mem_err    <= (mem_addr >= 32'h3C4) && (mem_addr < 32'h3D0);
    if (mem_req && mem_addr == poison_addr) poison_hit <= 1'b1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [31:0] d; logic [2:0] b; logic l; } beat_t;
  beat_t exp_q[$];
  int    beats_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int word_idx, input int nb, input bit last);
    beat_t b;
    b.d = mem[word_idx]; b.b = 3'(nb); b.l = last;
    exp_q.push_back(b);
  endtask

  // monitor: ready pattern is set at negedge, handshake checked before the next edge
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      out_ready = (k % 5) != 1 && (k % 7) != 3;
      k++;
      #1;
      if (out_valid && out_ready) begin
        beats_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R1/R8 unexpected beat", out_data, 32'h0);
        else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(out_data == e.d, "R1/R2 beat data", out_data, e.d);
          chk(out_bytes == e.b, "R1 beat byte count", 32'(out_bytes), 32'(e.b));
          chk(out_last == e.l, "R5 last flag", 32'(out_last), 32'(e.l));
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_status(input logic [31:0] m);
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(12'h480, s);
      if ((s & m) != 0) break;
    end
  endtask

  task automatic put_desc(input int idx, input logic [31:0] a, input logic [31:0] l,
                          input logic [31:0] n, input logic [31:0] f);
    mem[idx] = a; mem[idx+1] = l; mem[idx+2] = n; mem[idx+3] = f;
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0103;
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 1'b0, "R11 irq after reset", 32'(irq), 0);
    chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 0);
    chk(mem_req == 1'b0, "R11 mem_req after reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    rd(12'h480, v);
    chk(v == 0, "R11 status after reset", v, 0);

    wr(12'h484, 32'h1FF);
    wr(12'h488, 32'h1);

    // R1 direct mode, 10 bytes from 0x100
    push(8'h40, 4, 0); push(8'h41, 4, 0); push(8'h42, 2, 1);
    wr(12'h400, 32'h100);
    wr(12'h408, 32'd10);
    wr(12'h410, 32'h8000_0000);
    wait_status(32'h1);
    rd(12'h480, v);
    chk(v == 32'h1, "R6 done status after direct", v, 32'h1);
    chk(exp_q.size() == 0, "R1 all direct beats seen", 32'(exp_q.size()), 0);
    chk(irq == 1'b1, "R6 irq raised", 32'(irq), 1);
    wr(12'h480, 32'h0);
    rd(12'h480, v);
    chk(v == 32'h1, "R7 zero write keeps status", v, 32'h1);
    wr(12'h480, 32'h1);
    rd(12'h480, v);
    chk(v == 32'h0, "R7 one write clears status", v, 0);
    chk(irq == 1'b0, "R7 irq drops after clear", 32'(irq), 0);

    // R2/R3/R4 chained mode
    put_desc(8'h80, 32'h300, 32'd8, 32'h210, 32'h0);
    put_desc(8'h84, 32'h340, 32'd0, 32'h220, 32'h0);
    put_desc(8'h88, 32'h380, 32'd5, 32'h3F0, 32'h8000_0000);
    poison_addr = 32'h3F0;
    push(8'hC0, 4, 0); push(8'hC1, 4, 0);
    push(8'hE0, 4, 0); push(8'hE1, 1, 1);
    wr(12'h418, 32'h200);
    wr(12'h408, 32'h0);
    wr(12'h40C, 32'h0);
    wr(12'h410, 32'hF200_0000);
    wr(12'h410, 32'hF200_0000);   // R10 write while busy must not restart
    rd(12'h410, v);
    chk(v == 32'hF200_0000, "R10 mode readback with snoop field", v, 32'hF200_0000);
    wait_status(32'h1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all chained beats seen", 32'(exp_q.size()), 0);
    chk(poison_hit == 1'b0, "R3 terminated next pointer not read", 32'(poison_hit), 0);
    chk(beats_seen == 7, "R4 zero-length descriptor emits nothing", 32'(beats_seen), 7);

    // R9 mask
    wr(12'h488, 32'h0);
    #1 chk(irq == 1'b0, "R9 irq masked", 32'(irq), 0);
    wr(12'h488, 32'h1);
    #1 chk(irq == 1'b1, "R9 irq unmasked", 32'(irq), 1);
    wr(12'h480, 32'h1FF);

    // R8 read error on second data word
    push(8'hF0, 4, 0);
    wr(12'h400, 32'h3C0);
    wr(12'h408, 32'd12);
    wr(12'h410, 32'h8000_0000);
    wait_status(32'h10);
    rd(12'h480, v);
    chk(v == 32'h10, "R8 error bit without done", v, 32'h10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #2;
      chk(!out_valid && !mem_req, "R8 engine halted", {30'b0, out_valid, mem_req}, 0);
    end
    chk(exp_q.size() == 0 && beats_seen == 8, "R8 beat before error only", 32'(beats_seen), 8);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule